// File: doc/BRIEF.md
# Framed Byte-Stream Packet Receiver

This block sits behind a UART byte receiver and turns a free-running stream of bytes into fixed-length packets. A packet is ten bytes. It opens with a header byte of 0xEA and closes with a trailer byte of 0xAE. Between them are six payload bytes, followed by a 16-bit additive checksum of the payload. The checksum is sent high byte first. Two of the payload positions carry sampled ADC values, so the consumer depends on each field arriving at a fixed output position.

A receiver that simply counts ten bytes from wherever reception began would rotate the fields through its buffer. This block avoids that. It hunts for the header and accepts a packet only when the trailer sits exactly nine bytes later. It then verifies the checksum before presenting the payload with a one-cycle valid pulse. If the trailer is wrong, the block reports a framing error. It then looks back over the bytes it has already collected for a later header byte, so that a real packet hidden behind a false header is not lost. If the checksum is wrong, the block reports a checksum error and leaves the previous payload in place.

Top module: `pkt_frame_rx`

## Requirements
- R1: After reset, pay_valid, frame_err and sum_err are low and pay_data is all zeros.
- R2: While hunting, every accepted byte other than 0xEA is discarded and produces no output event.
- R3: Packet layout: byte 0 is 0xEA, bytes 1..6 are payload, byte 7 is the checksum high byte, byte 8 is the checksum low byte, and byte 9 is 0xAE. Output lane k (pay_data bits 8k+7:8k, k = 0..5) carries packet byte k+1.
- R4: For a good packet, pay_valid is high for exactly the one cycle after the clock edge that accepts the trailer byte.
- R5: The checksum is the sum, modulo 2^16, of packet bytes 1..6. If the trailer is correct but the checksum does not match, sum_err pulses for one cycle in place of pay_valid, and the block returns to hunting.
- R6: If any byte other than 0xAE arrives in the trailer position, frame_err pulses for one cycle and pay_valid stays low.
- R7: On a framing error, the earliest 0xEA among packet bytes 1..9 of the rejected frame is taken as a new header. The bytes after it are kept as the start of the next packet. If no such byte exists, the block hunts.
- R8: A stream that begins in the middle of a packet still delivers the following complete packet with every payload byte in its correct lane.
- R9: Bytes presented while in_valid is low are ignored, whatever their value.
- R10: pay_data changes only in the cycle where pay_valid is high and holds its value through errors and idle time.
- R11: At most one of pay_valid, frame_err and sum_err is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | in_data holds a received byte this cycle |
| in_data | input | 8 | Received byte |
| pay_valid | output | 1 | One-cycle pulse: a good packet's payload is on pay_data |
| pay_data | output | 48 | Six payload bytes; lane k holds packet byte k+1 |
| frame_err | output | 1 | One-cycle pulse: wrong byte in the trailer position |
| sum_err | output | 1 | One-cycle pulse: trailer correct, checksum mismatch |

## Verification
A wrong byte counter or a wrong realignment shows at the ports within one packet time. It appears either as a frame_err where a good packet was expected, or as a pay_valid carrying bytes shifted across lanes. The scoreboard compares every event against the expected cycle and payload. A wrong checksum order or sum shows as sum_err on the very next trailer. A payload register that updates when it should not shows as changed pay_data at the next error event or at the idle checks. The rescan case uses a false header two bytes ahead of a real packet, so a failure to look back turns the expected good packet into a missing event.

// File: rtl/pkt_frame_pkg.sv
package pkt_frame_pkg;

   typedef enum logic {
      ST_HUNT    = 1'b0,
      ST_COLLECT = 1'b1
   } rx_state_e;

   typedef enum logic [1:0] {
      EV_NONE  = 2'd0,
      EV_GOOD  = 2'd1,
      EV_SUM   = 2'd2,
      EV_FRAME = 2'd3
   } rx_event_e;

endpackage

// File: rtl/pkt_hdr_scan.sv
module pkt_hdr_scan #(
   parameter int                DATA_W = 8,
   parameter int                NUM    = 9,
   parameter logic [DATA_W-1:0] MATCH  = 8'hEA,
   parameter int                IDX_W  = $clog2(NUM + 1)
) (
   input  logic [NUM*DATA_W-1:0] bytes_i,
   output logic                  hit_o,
   output logic [IDX_W-1:0]      idx_o
);

   logic [NUM-1:0] eq_w;

   genvar g;
   generate
      for (g = 0; g < NUM; g++) begin : g_cmp
         assign eq_w[g] = (bytes_i[g*DATA_W +: DATA_W] == MATCH);
      end
   endgenerate

   // lowest slot wins
   always_comb begin
      hit_o = 1'b0;
      idx_o = '0;
      for (int i = NUM - 1; i >= 0; i--) begin
         if (eq_w[i]) begin
            hit_o = 1'b1;
            idx_o = IDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/pkt_sum_check.sv
module pkt_sum_check #(
   parameter int DATA_W   = 8,
   parameter int NPAY     = 6,
   parameter bit HI_FIRST = 1'b1
) (
   input  logic [NPAY*DATA_W-1:0] pay_i,
   input  logic [DATA_W-1:0]      ck_a_i,
   input  logic [DATA_W-1:0]      ck_b_i,
   output logic                   match_o
);

   localparam int SUM_W = 2 * DATA_W;

   logic [SUM_W-1:0] acc_w;
   logic [SUM_W-1:0] rx_sum_w;

   always_comb begin
      acc_w = '0;
      for (int i = 0; i < NPAY; i++) begin
         acc_w = acc_w + SUM_W'(pay_i[i*DATA_W +: DATA_W]);
      end
   end

   generate
      if (HI_FIRST) begin : g_hi_first
         assign rx_sum_w = {ck_a_i, ck_b_i};
      end else begin : g_lo_first
         assign rx_sum_w = {ck_b_i, ck_a_i};
      end
   endgenerate

   assign match_o = (acc_w == rx_sum_w);

endmodule

// File: rtl/pkt_frame_rx.sv
module pkt_frame_rx #(
   parameter int                DATA_W      = 8,
   parameter int                PKT_LEN     = 10,
   parameter logic [DATA_W-1:0] HDR_VAL     = 8'hEA,
   parameter logic [DATA_W-1:0] TRL_VAL     = 8'hAE,
   parameter bit                CK_HI_FIRST = 1'b1
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            in_valid,
   input  logic [DATA_W-1:0]               in_data,
   output logic                            pay_valid,
   output logic [(PKT_LEN-4)*DATA_W-1:0]   pay_data,
   output logic                            frame_err,
   output logic                            sum_err
);

   import pkt_frame_pkg::*;

   localparam int PAY_N  = PKT_LEN - 4;
   localparam int BODY_N = PKT_LEN - 1;
   localparam int HELD_N = PKT_LEN - 2;
   localparam int CNT_W  = $clog2(PKT_LEN);
   localparam int IDX_W  = $clog2(BODY_N + 1);

   generate
      if (PKT_LEN < 5) begin : g_bad_len
         $error("pkt_frame_rx: PKT_LEN must leave room for header, payload, checksum and trailer");
      end
      if (DATA_W < 2) begin : g_bad_width
         $error("pkt_frame_rx: DATA_W too small");
      end
      if (HDR_VAL == TRL_VAL) begin : g_bad_marks
         $error("pkt_frame_rx: header and trailer values must differ");
      end
   endgenerate

   rx_state_e         state_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [DATA_W-1:0] held_q [HELD_N];

   logic [DATA_W-1:0]        body_a   [BODY_N];
   logic [BODY_N*DATA_W-1:0] body_flat;
   logic [DATA_W-1:0]        realign_a [HELD_N];
   logic [CNT_W-1:0]         realign_cnt;
   logic                     hit_w;
   logic [IDX_W-1:0]         hit_idx;
   logic                     sum_ok;
   logic                     at_trailer;
   rx_event_e                event_w;

   // body slot k = packet byte k+1; last slot is the byte on the input
   genvar g;
   generate
      for (g = 0; g < BODY_N; g++) begin : g_body
         if (g < HELD_N) begin : g_held
            assign body_a[g] = held_q[g];
         end else begin : g_live
            assign body_a[g] = in_data;
         end
         assign body_flat[g*DATA_W +: DATA_W] = body_a[g];
      end
   endgenerate

   pkt_hdr_scan #(
      .DATA_W (DATA_W),
      .NUM    (BODY_N),
      .MATCH  (HDR_VAL),
      .IDX_W  (IDX_W)
   ) u_scan (
      .bytes_i (body_flat),
      .hit_o   (hit_w),
      .idx_o   (hit_idx)
   );

   pkt_sum_check #(
      .DATA_W   (DATA_W),
      .NPAY     (PAY_N),
      .HI_FIRST (CK_HI_FIRST)
   ) u_sum (
      .pay_i   (body_flat[PAY_N*DATA_W-1:0]),
      .ck_a_i  (body_a[PAY_N]),
      .ck_b_i  (body_a[PAY_N+1]),
      .match_o (sum_ok)
   );

   // shift the frame so that the byte after the found header lands in slot 0
   always_comb begin
      for (int k = 0; k < HELD_N; k++) begin
         realign_a[k] = '0;
         for (int s = 0; s < BODY_N; s++) begin
            if (s == int'(hit_idx) + 1 + k) begin
               realign_a[k] = body_a[s];
            end
         end
      end
      realign_cnt = CNT_W'(BODY_N - 1) - CNT_W'(hit_idx);
   end

   assign at_trailer = (state_q == ST_COLLECT) && (cnt_q == CNT_W'(HELD_N));

   always_comb begin
      event_w = EV_NONE;
      if (in_valid && at_trailer) begin
         if (in_data != TRL_VAL) begin
            event_w = EV_FRAME;
         end else if (sum_ok) begin
            event_w = EV_GOOD;
         end else begin
            event_w = EV_SUM;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_HUNT;
         cnt_q     <= '0;
         pay_valid <= 1'b0;
         frame_err <= 1'b0;
         sum_err   <= 1'b0;
         pay_data  <= '0;
         for (int k = 0; k < HELD_N; k++) begin
            held_q[k] <= '0;
         end
      end else begin
         pay_valid <= (event_w == EV_GOOD);
         sum_err   <= (event_w == EV_SUM);
         frame_err <= (event_w == EV_FRAME);
         if (in_valid) begin
            unique case (state_q)
               ST_HUNT: begin
                  if (in_data == HDR_VAL) begin
                     state_q <= ST_COLLECT;
                     cnt_q   <= '0;
                  end
               end
               ST_COLLECT: begin
                  if (!at_trailer) begin
                     for (int k = 0; k < HELD_N; k++) begin
                        if (cnt_q == CNT_W'(k)) begin
                           held_q[k] <= in_data;
                        end
                     end
                     cnt_q <= cnt_q + 1'b1;
                  end else if (event_w == EV_FRAME) begin
                     if (hit_w) begin
                        cnt_q <= realign_cnt;
                        for (int k = 0; k < HELD_N; k++) begin
                           held_q[k] <= realign_a[k];
                        end
                     end else begin
                        state_q <= ST_HUNT;
                     end
                  end else begin
                     state_q <= ST_HUNT;
                     if (event_w == EV_GOOD) begin
                        pay_data <= body_flat[PAY_N*DATA_W-1:0];
                     end
                  end
               end
               default: state_q <= ST_HUNT;
            endcase
         end
      end
   end

endmodule

// File: rtl/pkt_frame_rx_chk.sv
module pkt_frame_rx_chk #(
   parameter int                DATA_W  = 8,
   parameter int                PKT_LEN = 10,
   parameter logic [DATA_W-1:0] TRL_VAL = 8'hAE
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          in_valid,
   input logic [DATA_W-1:0]             in_data,
   input logic                          pay_valid,
   input logic [(PKT_LEN-4)*DATA_W-1:0] pay_data,
   input logic                          frame_err,
   input logic                          sum_err
);

   assert_one_event_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pay_valid, frame_err, sum_err}));

   assert_pulse_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
      pay_valid |=> !pay_valid);

   assert_payload_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !pay_valid |-> $stable(pay_data));

   assert_event_from_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pay_valid || frame_err || sum_err) |-> $past(in_valid));

   assert_good_trailer_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pay_valid || sum_err) |-> ($past(in_data) == TRL_VAL));

   assert_bad_trailer_R6: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err |-> ($past(in_data) != TRL_VAL));

endmodule

bind pkt_frame_rx pkt_frame_rx_chk #(
   .DATA_W  (DATA_W),
   .PKT_LEN (PKT_LEN),
   .TRL_VAL (TRL_VAL)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_data   (in_data),
   .pay_valid (pay_valid),
   .pay_data  (pay_data),
   .frame_err (frame_err),
   .sum_err   (sum_err)
);

// File: tb/sim_pkt_frame_rx.sv
module sim_pkt_frame_rx;

   localparam logic [7:0] HDR = 8'hEA;
   localparam logic [7:0] TRL = 8'hAE;

   typedef struct {
      int          kind;   // 0 good, 1 checksum error, 2 framing error
      logic [47:0] pay;
      string       req;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [7:0]  in_data = 8'h00;
   logic        pay_valid;
   logic [47:0] pay_data;
   logic        frame_err;
   logic        sum_err;

   int          checks = 0;
   int          errors = 0;
   logic [47:0] last_good = '0;
   exp_t        q[$];
   bit          done = 1'b0;

   always #4 clk = ~clk;

   pkt_frame_rx u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_data   (in_data),
      .pay_valid (pay_valid),
      .pay_data  (pay_data),
      .frame_err (frame_err),
      .sum_err   (sum_err)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] csum(input logic [47:0] p);
      logic [15:0] s = 16'h0;
      for (int i = 0; i < 6; i++) s = s + {8'h00, p[i*8 +: 8]};
      return s;
   endfunction

   task automatic send_byte(input logic [7:0] b);
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = b;
   endtask

   // idle cycles carry the header value to show it is ignored (R9)
   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
         in_data  = HDR;
      end
   endtask

   task automatic expect_evt(input int kind, input logic [47:0] p, input string req);
      exp_t e;
      e.kind = kind;
      e.pay  = p;
      e.req  = req;
      q.push_back(e);
   endtask

   // mode 0 good, 1 corrupt checksum, 2 wrong trailer; gap inserts idle cycles
   task automatic send_packet(input logic [47:0] p, input int mode, input int gap,
                              input string req);
      logic [15:0] s = csum(p);
      if (mode == 1) s = s ^ 16'h0001;
      send_byte(HDR);
      for (int i = 0; i < 6; i++) begin
         if (gap > 0) idle(gap);
         send_byte(p[i*8 +: 8]);
      end
      send_byte(s[15:8]);
      send_byte(s[7:0]);
      if (gap > 0) idle(gap);
      send_byte(mode == 2 ? 8'h55 : TRL);
      expect_evt(mode, p, req);
   endtask

   // scoreboard monitor: samples one time unit after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (rst_n && !done) begin
            int nev;
            int kind;
            nev = int'(pay_valid) + int'(frame_err) + int'(sum_err);
            kind = pay_valid ? 0 : (sum_err ? 1 : 2);
            if (nev > 1) check(1'b0, "R11", "several event pulses", 64'(nev), 64'd1);
            if (nev >= 1) begin
               if (q.size() == 0) begin
                  check(1'b0, "R2", "unexpected event kind", 64'(kind), 64'hFF);
               end else begin
                  exp_t e;
                  e = q.pop_front();
                  check(kind == e.kind, e.req, "event kind", 64'(kind), 64'(e.kind));
                  if (e.kind == 0) begin
                     check(pay_data == e.pay, e.req, "payload lanes", 64'(pay_data), 64'(e.pay));
                     last_good = e.pay;
                  end else begin
                     check(pay_data == last_good, "R10", "payload held on error",
                           64'(pay_data), 64'(last_good));
                  end
               end
            end else if (q.size() != 0) begin
               exp_t e;
               e = q.pop_front();
               check(1'b0, e.req, "missing event kind", 64'hFF, 64'(e.kind));
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      check(1'b0, "WDOG", "run did not finish", 64'd0, 64'd1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [47:0] pa, pb, px, pc;
      logic [15:0] sx;

      // R1: reset state
      repeat (3) @(posedge clk);
      #1;
      check({pay_valid, frame_err, sum_err} == 3'b000, "R1", "pulses in reset",
            64'({pay_valid, frame_err, sum_err}), 64'd0);
      check(pay_data == '0, "R1", "payload in reset", 64'(pay_data), 64'd0);
      @(negedge clk);
      rst_n = 1'b1;
      idle(2);

      // R3 R4 R5: plain good packet, payload containing the header value
      pa = 48'h665544EA2211;
      send_packet(pa, 0, 0, "R3");
      idle(3);

      // R9: same framing with idle gaps carrying the header value
      pb = 48'h0C0B0A090807;
      send_packet(pb, 0, 2, "R9");
      idle(3);

      // R2: garbage without a header produces nothing
      send_byte(TRL); send_byte(8'h00); send_byte(8'hFF); send_byte(8'h13);
      idle(4);
      check(pay_data == last_good, "R2", "payload after garbage", 64'(pay_data), 64'(last_good));

      // R8: stream starts mid-packet (tail of another packet), then a full packet
      px = 48'h060504030201;
      sx = csum(px);
      send_byte(px[31:24]); send_byte(px[39:32]); send_byte(px[47:40]);
      send_byte(sx[15:8]); send_byte(sx[7:0]); send_byte(TRL);
      pb = 48'h7F3C1D2E4B5A;
      send_packet(pb, 0, 0, "R8");
      idle(2);

      // R5: checksum mismatch, then recovery with a good packet
      send_packet(48'h111111111111, 1, 0, "R5");
      idle(2);
      check(pay_data == last_good, "R10", "payload after checksum error",
            64'(pay_data), 64'(last_good));
      pa = 48'hFFFFFFFFFFFF;   // sum 0x05FA: non-zero high byte checks order
      send_packet(pa, 0, 0, "R5");
      idle(2);

      // R6: wrong trailer with no header inside the frame
      send_packet(48'h303132333435, 2, 0, "R6");
      idle(2);
      send_packet(48'h0102A0B0C0D0, 0, 0, "R6");
      idle(2);

      // R7: false header two bytes ahead of a real packet
      pc = 48'h262524232221;
      sx = csum(pc);
      send_byte(HDR); send_byte(8'h11); send_byte(8'h22);
      send_byte(HDR);
      for (int i = 0; i < 5; i++) send_byte(pc[i*8 +: 8]);
      send_byte(pc[47:40]);
      expect_evt(2, '0, "R7");
      send_byte(sx[15:8]);
      send_byte(sx[7:0]);
      send_byte(TRL);
      expect_evt(0, pc, "R7");
      idle(2);

      // R4 R11: back-to-back packets with no gap
      send_packet(48'h0A0B0C0D0E0F, 0, 0, "R4");
      send_packet(48'h101112131415, 0, 0, "R11");
      idle(5);

      check(q.size() == 0, "R4", "events left pending", 64'(q.size()), 64'd0);
      check(pay_data == last_good, "R10", "payload held when idle", 64'(pay_data), 64'(last_good));
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule